// File: doc/BRIEF.md
# Lockstep Processor State Comparator

This block judges whether a model under test reproduces the architectural state of a reference processor, one executed instruction at a time. After each instruction both sides stream a configuration record: the whole mapped memory, registers and special function registers included, as one word per beat. Every beat also carries the program counter. The comparator joins the two streams beat by beat. It declares a step equivalent only when the program counter and every memory word agree, and the address sequence and end-of-step marker are as expected.

Software starts a batch by giving a step limit and a program count. Each program is then compared as an initial-configuration step (index 0, before any instruction) plus one step per executed instruction, up to the limit. At the end of each program a one-cycle verdict reports the program number and a pass bit. A failed program also reports the index of its first mismatching step and whether more than one step failed. Executing instructions, building test programs and moving the dumps between machines are done elsewhere.

Top module: `lockstep_cmp`

## Requirements
- R1: After a synchronous reset `busy`, `verdict_valid`, `ref_ready` and `dut_ready` are all 0, whatever the valid inputs do.
- R2: While idle, `start` with a nonzero `cfg_programs` sets `busy` on the next edge and latches both configuration inputs. `start` while busy is ignored. `start` with `cfg_programs` equal to 0 is ignored.
- R3: A beat is consumed only when `busy` is 1 and both sides are valid. `ref_ready` equals `busy` and `dut_valid`, and `dut_ready` equals `busy` and `ref_valid`.
- R4: A step is MEM_WORDS beats. Beat k must carry address k on both sides. Each side's end-of-step marker must be 1 on beat MEM_WORDS-1 and 0 elsewhere. A marker on either side ends the step early. Any address or marker deviation makes the step fail.
- R5: On every beat of a step, `ref_data` must equal `dut_data`, or the step fails.
- R6: On the beat that ends a step, `ref_pc` must equal `dut_pc`. In step 0 that program counter must also equal RESET_VEC (0x0000). Program counters on other beats are not compared.
- R7: Each program has `cfg_steps`+1 steps, indexed 0 to `cfg_steps`. On the edge that consumes a program's final beat, the verdict registers load. `verdict_valid` is then 1 for one cycle, with `verdict_prog` holding the program number (0 for the first program of a batch).
- R8: A program whose steps all matched gives `verdict_pass`=1, `verdict_step`=0 and `verdict_multi`=0.
- R9: A failed program gives `verdict_pass`=0, with `verdict_step` set to the lowest failing step index. `verdict_multi` is 1 exactly when two or more of its steps failed.
- R10: On the edge that loads the verdict of program `cfg_programs`-1, `busy` drops, so both ready outputs fall with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a batch (idle only) |
| cfg_steps | input | STEP_W | Highest step index per program |
| cfg_programs | input | PROG_W | Number of programs in the batch |
| busy | output | 1 | Batch in progress |
| ref_valid | input | 1 | Reference beat present |
| ref_ready | output | 1 | Reference beat taken this cycle |
| ref_pc | input | PC_W | Reference program counter |
| ref_addr | input | ADDR_W | Reference word address |
| ref_data | input | DATA_W | Reference word value |
| ref_last | input | 1 | Reference end-of-step marker |
| dut_valid | input | 1 | Model beat present |
| dut_ready | output | 1 | Model beat taken this cycle |
| dut_pc | input | PC_W | Model program counter |
| dut_addr | input | ADDR_W | Model word address |
| dut_data | input | DATA_W | Model word value |
| dut_last | input | 1 | Model end-of-step marker |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_prog | output | PROG_W | Program number of the verdict |
| verdict_pass | output | 1 | 1 when every step matched |
| verdict_step | output | STEP_W | First failing step index, 0 on pass |
| verdict_multi | output | 1 | More than one step failed |

## Verification
The bench sweeps every subset of failing steps in a four-step program and rotates six fault kinds through them. The kinds are a data flip, a wrong address, a program counter that differs only on the end beat, an early marker on both sides, a marker missing on one side, and an equal but nonzero counter. A design that compared the program counter on the wrong beat, or that kept the reset-vector rule after step 0, would pass or fail the wrong programs. So would one that let an early marker through unflagged. A design that overwrote the first failing index on a later failure, or that raised the multiple flag for a single failure, would report the wrong `verdict_step` or `verdict_multi`. The bench also holds only one side valid to check the ready pairing. It issues starts while busy and with zero programs, which a careless design would act on and so renumber or restart the batch.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;
  typedef enum logic {
    MODE_IDLE = 1'b0,
    MODE_RUN  = 1'b1
  } run_mode_t;
endpackage

// File: rtl/lcmp_beat_judge.sv
module lcmp_beat_judge #(
  parameter int MEM_WORDS = 16,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PC_W      = 16,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic [ADDR_W-1:0] beat_idx,
  input  logic              first_step,
  input  logic [PC_W-1:0]   ref_pc,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [DATA_W-1:0] ref_data,
  input  logic              ref_last,
  input  logic [PC_W-1:0]   dut_pc,
  input  logic [ADDR_W-1:0] dut_addr,
  input  logic [DATA_W-1:0] dut_data,
  input  logic              dut_last,
  output logic              beat_end,
  output logic              beat_bad
);
  localparam logic [ADDR_W-1:0] FINAL_IDX = ADDR_W'(MEM_WORDS - 1);

  function automatic logic addr_ok(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b,
                                   input logic [ADDR_W-1:0] idx);
    return (a == idx) && (b == idx);
  endfunction

  function automatic logic pc_ok(input logic end_beat, input logic step0,
                                 input logic [PC_W-1:0] a, input logic [PC_W-1:0] b);
    if (!end_beat) return 1'b1;
    return (a == b) && (!step0 || a == RESET_VEC);
  endfunction

  logic beat_final;
  logic marker_ok;

  always_comb begin
    beat_final = (beat_idx == FINAL_IDX);
    beat_end   = ref_last | dut_last | beat_final;
    marker_ok  = (ref_last == beat_final) && (dut_last == beat_final);
    beat_bad   = !(addr_ok(ref_addr, dut_addr, beat_idx) && (ref_data == dut_data) &&
                   marker_ok && pc_ok(beat_end, first_step, ref_pc, dut_pc));
  end
endmodule

// File: rtl/lcmp_sequencer.sv
module lcmp_sequencer
  import lcmp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STEP_W = 16,
  parameter int PROG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [STEP_W-1:0] cfg_steps,
  input  logic [PROG_W-1:0] cfg_programs,
  input  logic              fire,
  input  logic              beat_end,
  output logic              busy,
  output logic [ADDR_W-1:0] beat_idx,
  output logic [STEP_W-1:0] step_idx,
  output logic [PROG_W-1:0] prog_idx,
  output logic [STEP_W-1:0] steps_lim,
  output logic              step_done,
  output logic              prog_done
);
  run_mode_t         mode_q;
  logic [PROG_W-1:0] progs_q;
  logic              last_step;
  logic              last_prog;

  always_comb begin
    busy      = (mode_q == MODE_RUN);
    last_step = (step_idx == steps_lim);
    last_prog = (prog_idx == progs_q - 1'b1);
    step_done = fire & beat_end;
    prog_done = step_done & last_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_IDLE;
      beat_idx  <= '0;
      step_idx  <= '0;
      prog_idx  <= '0;
      steps_lim <= '0;
      progs_q   <= '0;
    end else if (mode_q == MODE_IDLE) begin
      if (start && cfg_programs != '0) begin
        mode_q    <= MODE_RUN;
        steps_lim <= cfg_steps;
        progs_q   <= cfg_programs;
        beat_idx  <= '0;
        step_idx  <= '0;
        prog_idx  <= '0;
      end
    end else if (fire) begin
      if (beat_end) begin
        beat_idx <= '0;
        if (last_step) begin
          step_idx <= '0;
          if (last_prog) mode_q <= MODE_IDLE;
          else           prog_idx <= prog_idx + 1'b1;
        end else begin
          step_idx <= step_idx + 1'b1;
        end
      end else begin
        beat_idx <= beat_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcmp_verdict.sv
module lcmp_verdict #(
  parameter int STEP_W = 16,
  parameter int PROG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              beat_end,
  input  logic              beat_bad,
  input  logic              step_done,
  input  logic              prog_done,
  input  logic [STEP_W-1:0] step_idx,
  input  logic [PROG_W-1:0] prog_idx,
  output logic              step_fail,
  output logic              verdict_valid,
  output logic [PROG_W-1:0] verdict_prog,
  output logic              verdict_pass,
  output logic [STEP_W-1:0] verdict_step,
  output logic              verdict_multi
);
  logic              step_bad_q;
  logic              seen_q;
  logic [STEP_W-1:0] first_q;
  logic              multi_q;

  function automatic logic [STEP_W-1:0] report_idx(input logic seen, input logic [STEP_W-1:0] first,
                                                   input logic fail_now, input logic [STEP_W-1:0] now);
    if (seen)     return first;
    if (fail_now) return now;
    return '0;
  endfunction

  assign step_fail = step_done & (step_bad_q | beat_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_bad_q    <= 1'b0;
      seen_q        <= 1'b0;
      first_q       <= '0;
      multi_q       <= 1'b0;
      verdict_valid <= 1'b0;
      verdict_prog  <= '0;
      verdict_pass  <= 1'b0;
      verdict_step  <= '0;
      verdict_multi <= 1'b0;
    end else begin
      verdict_valid <= prog_done;
      if (fire) step_bad_q <= beat_end ? 1'b0 : (step_bad_q | beat_bad);
      if (prog_done) begin
        seen_q        <= 1'b0;
        multi_q       <= 1'b0;
        verdict_prog  <= prog_idx;
        verdict_pass  <= !(seen_q | step_fail);
        verdict_step  <= report_idx(seen_q, first_q, step_fail, step_idx);
        verdict_multi <= multi_q | (seen_q & step_fail);
      end else if (step_fail) begin
        if (seen_q) begin
          multi_q <= 1'b1;
        end else begin
          seen_q  <= 1'b1;
          first_q <= step_idx;
        end
      end
    end
  end
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
  parameter int MEM_WORDS = 16,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PC_W      = 16,
  parameter int STEP_W    = 16,
  parameter int PROG_W    = 8,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [STEP_W-1:0] cfg_steps,
  input  logic [PROG_W-1:0] cfg_programs,
  output logic              busy,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [PC_W-1:0]   ref_pc,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [DATA_W-1:0] ref_data,
  input  logic              ref_last,
  input  logic              dut_valid,
  output logic              dut_ready,
  input  logic [PC_W-1:0]   dut_pc,
  input  logic [ADDR_W-1:0] dut_addr,
  input  logic [DATA_W-1:0] dut_data,
  input  logic              dut_last,
  output logic              verdict_valid,
  output logic [PROG_W-1:0] verdict_prog,
  output logic              verdict_pass,
  output logic [STEP_W-1:0] verdict_step,
  output logic              verdict_multi
);
  logic              fire;
  logic              beat_end;
  logic              beat_bad;
  logic              step_done;
  logic              prog_done;
  logic              step_fail;
  logic [ADDR_W-1:0] beat_idx;
  logic [STEP_W-1:0] step_idx;
  logic [PROG_W-1:0] prog_idx;
  logic [STEP_W-1:0] steps_lim;

  assign ref_ready = busy & dut_valid;
  assign dut_ready = busy & ref_valid;
  assign fire      = busy & ref_valid & dut_valid;

  lcmp_sequencer #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .PROG_W(PROG_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_steps(cfg_steps), .cfg_programs(cfg_programs),
    .fire(fire), .beat_end(beat_end), .busy(busy), .beat_idx(beat_idx), .step_idx(step_idx),
    .prog_idx(prog_idx), .steps_lim(steps_lim), .step_done(step_done), .prog_done(prog_done)
  );

  lcmp_beat_judge #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W),
                    .RESET_VEC(RESET_VEC)) u_judge (
    .beat_idx(beat_idx), .first_step(step_idx == '0),
    .ref_pc(ref_pc), .ref_addr(ref_addr), .ref_data(ref_data), .ref_last(ref_last),
    .dut_pc(dut_pc), .dut_addr(dut_addr), .dut_data(dut_data), .dut_last(dut_last),
    .beat_end(beat_end), .beat_bad(beat_bad)
  );

  lcmp_verdict #(.STEP_W(STEP_W), .PROG_W(PROG_W)) u_verdict (
    .clk(clk), .rst(rst), .fire(fire), .beat_end(beat_end), .beat_bad(beat_bad),
    .step_done(step_done), .prog_done(prog_done), .step_idx(step_idx), .prog_idx(prog_idx),
    .step_fail(step_fail), .verdict_valid(verdict_valid), .verdict_prog(verdict_prog),
    .verdict_pass(verdict_pass), .verdict_step(verdict_step), .verdict_multi(verdict_multi)
  );
endmodule

// File: rtl/lcmp_checker.sv
module lcmp_checker #(
  parameter int STEP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              ref_valid,
  input logic              dut_valid,
  input logic              ref_ready,
  input logic              dut_ready,
  input logic              prog_done,
  input logic [STEP_W-1:0] steps_lim,
  input logic              verdict_valid,
  input logic              verdict_pass,
  input logic [STEP_W-1:0] verdict_step,
  input logic              verdict_multi
);
  p_ref_ready_pair_r3: assert property (@(posedge clk) disable iff (rst)
    ref_ready |-> (busy && dut_valid));
  p_dut_ready_pair_r3: assert property (@(posedge clk) disable iff (rst)
    dut_ready |-> (busy && ref_valid));
  p_pulse_follows_end_r7: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> $past(prog_done));
  p_pass_is_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict_pass) |-> (verdict_step == '0 && !verdict_multi));
  p_multi_means_fail_r9: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict_multi) |-> !verdict_pass);
  p_step_in_range_r9: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> (verdict_step <= $past(steps_lim)));
  p_busy_ends_on_verdict_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> verdict_valid);
endmodule

bind lockstep_cmp lcmp_checker #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ref_valid(ref_valid), .dut_valid(dut_valid),
  .ref_ready(ref_ready), .dut_ready(dut_ready), .prog_done(prog_done), .steps_lim(steps_lim),
  .verdict_valid(verdict_valid), .verdict_pass(verdict_pass), .verdict_step(verdict_step),
  .verdict_multi(verdict_multi)
);

// File: tb/lockstep_cmp_bench.sv
module lockstep_cmp_bench;
  localparam int MW = 4;
  localparam int AW = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] cfg_steps = '0;
  logic [7:0]  cfg_programs = '0;
  logic        busy;
  logic        ref_valid = 1'b0, dut_valid = 1'b0;
  logic        ref_ready, dut_ready;
  logic [15:0] ref_pc = '0, dut_pc = '0;
  logic [AW-1:0] ref_addr = '0, dut_addr = '0;
  logic [7:0]  ref_data = '0, dut_data = '0;
  logic        ref_last = 1'b0, dut_last = 1'b0;
  logic        verdict_valid;
  logic [7:0]  verdict_prog;
  logic        verdict_pass;
  logic [15:0] verdict_step;
  logic        verdict_multi;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        pend = 1'b0;
  logic [7:0]  pend_prog;
  logic        pend_pass;
  logic [15:0] pend_step;
  logic        pend_multi;

  always #10 clk = ~clk;

  lockstep_cmp #(.MEM_WORDS(MW), .ADDR_W(AW)) u_lockstep_cmp (
    .clk(clk), .rst(rst), .start(start), .cfg_steps(cfg_steps), .cfg_programs(cfg_programs),
    .busy(busy), .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_pc(ref_pc),
    .ref_addr(ref_addr), .ref_data(ref_data), .ref_last(ref_last), .dut_valid(dut_valid),
    .dut_ready(dut_ready), .dut_pc(dut_pc), .dut_addr(dut_addr), .dut_data(dut_data),
    .dut_last(dut_last), .verdict_valid(verdict_valid), .verdict_prog(verdict_prog),
    .verdict_pass(verdict_pass), .verdict_step(verdict_step), .verdict_multi(verdict_multi)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge, before new inputs are driven
  task automatic check_verdict();
    chk(verdict_valid == pend, "R7 verdict strobe", 32'(verdict_valid), 32'(pend));
    if (pend && verdict_valid) begin
      chk(verdict_prog == pend_prog, "R7 program number", 32'(verdict_prog), 32'(pend_prog));
      chk(verdict_pass == pend_pass, "R8 pass bit", 32'(verdict_pass), 32'(pend_pass));
      chk(verdict_step == pend_step, "R9 first failing step", 32'(verdict_step), 32'(pend_step));
      chk(verdict_multi == pend_multi, "R9 multiple flag", 32'(verdict_multi), 32'(pend_multi));
    end
  endtask

  task automatic beat(input logic [AW-1:0] ra, input logic [AW-1:0] da, input logic [7:0] rd,
                      input logic [7:0] dd, input logic [15:0] rpc, input logic [15:0] dpc,
                      input logic rl, input logic dl, input bit ends_prog);
    @(negedge clk);
    check_verdict();
    start = 1'b0;
    ref_valid = 1'b1; dut_valid = 1'b1;
    ref_addr = ra; dut_addr = da; ref_data = rd; dut_data = dd;
    ref_pc = rpc; dut_pc = dpc; ref_last = rl; dut_last = dl;
    @(posedge clk);
    pend = ends_prog;
  endtask

  task automatic idle(input logic st, input logic [15:0] cs, input logic [7:0] cp);
    @(negedge clk);
    check_verdict();
    ref_valid = 1'b0; dut_valid = 1'b0;
    start = st; cfg_steps = cs; cfg_programs = cp;
    @(posedge clk);
    pend = 1'b0;
  endtask

  // kind: 0 data, 1 address, 2 end-beat pc, 3 early marker both, 4 missing marker one side, 5 nonzero equal pc
  task automatic run_program(input int p, input int kind, input int mask, input int nsteps);
    int first = -1;
    int count = 0;
    for (int s = 0; s < nsteps; s++) begin
      bit f = mask[s] && (kind != 5 || s == 0);
      if (f) begin
        if (first < 0) first = s;
        count++;
      end
    end
    for (int s = 0; s < nsteps; s++) begin
      bit fault = mask[s];
      int nb = (fault && kind == 3) ? 2 : MW;
      for (int b = 0; b < nb; b++) begin
        logic [AW-1:0] ra = AW'(b), da = AW'(b);
        logic [7:0] rd = 8'(p * 7 + s * 3 + b), dd;
        logic [15:0] rpc = (s == 0) ? 16'h0 : 16'(16'h100 + s), dpc;
        logic rl = (b == MW - 1), dl;
        bit last_beat = (s == nsteps - 1) && (b == nb - 1);
        dd = rd; dpc = rpc; dl = rl;
        if (fault) begin
          case (kind)
            0: if (b == 2) dd = rd ^ 8'h01;           // R5
            1: if (b == 1) da = '0;                   // R4
            2: if (b == MW - 1) dpc = rpc ^ 16'h8;    // R6
            3: if (b == 1) begin rl = 1'b1; dl = 1'b1; end  // R4
            4: if (b == MW - 1) rl = 1'b0;            // R4
            default: begin rpc = 16'h33; dpc = 16'h33; end  // R6
          endcase
        end else if (kind == 2 && b != MW - 1) begin
          dpc = rpc ^ 16'h40;                         // R6: non-end beats not compared
        end
        if (last_beat) begin
          pend_prog = 8'(p);
          pend_pass = (count == 0);
          pend_step = (first < 0) ? 16'h0 : 16'(first);
          pend_multi = (count > 1);
        end
        beat(ra, da, rd, dd, rpc, dpc, rl, dl, last_beat);
      end
    end
  endtask

  initial begin
    ref_valid = 1'b1; dut_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
    chk(verdict_valid == 1'b0, "R1 verdict after reset", 32'(verdict_valid), 0);
    chk(ref_ready == 1'b0 && dut_ready == 1'b0, "R1 readies after reset",
        {ref_ready, dut_ready}, 0);
    rst = 1'b0;
    ref_valid = 1'b0; dut_valid = 1'b0;

    // R2: zero programs ignored
    idle(1'b1, 16'd3, 8'd0);
    idle(1'b0, 16'd3, 8'd0);
    chk(busy == 1'b0, "R2 zero-program start ignored", 32'(busy), 0);

    // Sweep: 16 programs, 4 steps each, every failure subset
    idle(1'b1, 16'd3, 8'd16);
    @(negedge clk);
    chk(busy == 1'b1, "R2 start sets busy", 32'(busy), 1);
    for (int p = 0; p < 16; p++) run_program(p, p % 6, p, 4);
    idle(1'b0, 16'd0, 8'd0);
    chk(busy == 1'b0, "R10 busy drops after last verdict", 32'(busy), 0);
    chk(ref_ready == 1'b0, "R10 ready low after batch", 32'(ref_ready), 0);

    // Second batch: 2 programs of 2 steps, start while busy ignored, one-sided valid
    idle(1'b1, 16'd1, 8'd2);
    idle(1'b1, 16'd0, 8'd5);    // R2: must be ignored
    @(negedge clk);
    check_verdict();
    start = 1'b0;
    ref_valid = 1'b1; dut_valid = 1'b0;
    #1;
    chk(ref_ready == 1'b0 && dut_ready == 1'b1, "R3 only reference valid",
        {ref_ready, dut_ready}, 32'b01);
    @(negedge clk);
    ref_valid = 1'b0; dut_valid = 1'b1;
    #1;
    chk(ref_ready == 1'b1 && dut_ready == 1'b0, "R3 only model valid",
        {ref_ready, dut_ready}, 32'b10);
    run_program(0, 0, 2, 2);
    idle(1'b0, 16'd0, 8'd0);
    chk(busy == 1'b1, "R2 batch length kept", 32'(busy), 1);
    run_program(1, 5, 3, 2);
    idle(1'b0, 16'd0, 8'd0);
    chk(busy == 1'b0, "R10 second batch ends", 32'(busy), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule